// File: doc/BRIEF.md
# Quadrature Encoder Pulse Divider

This block sits behind the line receivers of an incremental position encoder. It takes the A, B and index (Z) channels as single-ended logic levels, brings them into the clock domain and lowers the pulse rate by an 8-bit denominator. The result is a slower pulse train that a drive controller can count. A 12-position, active-low switch word sets the denominator and the output mode, and it also holds a counter-clear control.

The switch word selects one of three modes. In the divided-quadrature mode, both outputs form a quadrature pair that runs at 1/N of the input rate and keeps the input's lead/lag relation. In the lead-indicator mode, the second output is a flag that shows which phase leads. In the external-direction mode, the B input carries a direction level, and that level is passed to the second output in step with the divided A output. In every mode the index channel passes through with a fixed delay and is never divided.

Top module: `quad_pulse_divider`

## Requirements
- R1: Every switch field is the logical inverse of its raw pin (a pin reading 0, switch ON, gives field value 1). Switch position p is bit p-1 of `cfg_sw_n_i`. When all raw pins read 1, the counters are held clear.
- R2: The denominator N is the field on positions 5..12 (bits 11:4), and position 5 is the least significant bit. Over N input periods, each divided output completes exactly one period.
- R3: In divided-quadrature mode (position 2 = 0, position 3 = 0), the block keeps a position count P modulo 4N. P rises by one on each forward input quadrature step (A leads) and falls by one on each reverse step. The output state s = floor(P/N) mod 4 maps as follows: A_out = 1 for s = 1 or 2, and B_out = 1 for s = 2 or 3.
- R4: A denominator of 0 acts as 1, so the outputs reproduce the inputs.
- R5: In lead-indicator mode (position 2 = 0, position 3 = 1), A_out toggles on every N-th edge of A, counting both edges. B_out takes the level of B at the most recent rising edge of A, so 0 means A leads and 1 means B leads.
- R6: In external-direction mode (position 2 = 1, position 3 ignored), A_out is divided as in R5 and B_out equals the B input delayed by 3 clock cycles.
- R7: Z_out equals the Z input delayed by exactly 3 clock cycles in every configuration.
- R8: While the run field (position 4) is 0, all counters and the lead flag are held at zero, so A_out = 0. B_out = 0 in the two modes other than external-direction. After reset the block is in this cleared state.
- R9: The reserved position 1 has no effect on any output.
- R10: A step on A reaches the outputs exactly 3 clock cycles after it is applied (two synchronizer stages plus one counter register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a_i | input | 1 | Encoder phase A level |
| enc_b_i | input | 1 | Encoder phase B level, or direction level in external-direction mode |
| enc_z_i | input | 1 | Encoder index level |
| cfg_sw_n_i | input | 12 | Active-low switch word: position 1 reserved, 2 and 3 mode, 4 run, 5..12 denominator |
| a_out_o | output | 1 | Divided phase A |
| b_out_o | output | 1 | Divided phase B, lead flag or delayed direction, depending on mode |
| z_out_o | output | 1 | Delayed index |

## Verification
The assertions check four things on every cycle. The index and the external direction must track their inputs with a fixed three-cycle delay. The outputs must be forced to zero while the run field is cleared. In divided-quadrature mode, the output pair must never move more than one quadrature step per cycle. What only the scenarios can show is the arithmetic: the position modulo 4N and its reversal, the bit order of the denominator including the value 85, the zero-as-one rule, the lead flag following a change of direction, and the reserved switch having no effect. Each of these is checked against a reference model after every input step.

// File: rtl/qdp_pkg.sv
package qdp_pkg;

   typedef enum logic [1:0] {
      OM_QUAD   = 2'd0,
      OM_LEAD   = 2'd1,
      OM_EXTDIR = 2'd2
   } omode_e;

   typedef struct packed {
      logic z;
      logic b;
      logic a;
   } lvl_t;

   // Gray position of an A/B pair: 00->0, 10->1, 11->2, 01->3 (forward = A leads)
   function automatic logic [1:0] quad_idx(input logic a, input logic b);
      return {b, a ^ b};
   endfunction

endpackage

// File: rtl/qdp_sync.sv
module qdp_sync #(
   parameter int STAGES = 2,
   parameter int W      = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/qdp_front.sv
module qdp_front
   import qdp_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic a_i,
   input  logic b_i,
   input  logic z_i,
   output lvl_t cur,
   output lvl_t prev
);
   logic [2:0] synced;

   qdp_sync #(.STAGES(STAGES), .W(3)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({z_i, b_i, a_i}),
      .q     (synced)
   );

   assign cur = lvl_t'(synced);

   // one-cycle history: edge detection and the matched delay for pass-through channels
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '0;
      else        prev <= cur;
   end
endmodule

// File: rtl/qdp_quad_cnt.sv
module qdp_quad_cnt
   import qdp_pkg::*;
#(
   parameter int DEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  lvl_t             cur,
   input  lvl_t             prev,
   input  logic [DEN_W-1:0] n_m1,
   output logic [1:0]       st
);
   logic [DEN_W-1:0] sub;
   logic [1:0]       dlt;
   logic             fwd, rev;

   assign dlt = quad_idx(cur.a, cur.b) - quad_idx(prev.a, prev.b);
   assign fwd = en && (dlt == 2'd1);
   assign rev = en && (dlt == 2'd3);

   // position = st*N + sub, kept modulo 4N
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sub <= '0;
         st  <= '0;
      end else if (clr) begin
         sub <= '0;
         st  <= '0;
      end else if (fwd) begin
         if (sub == n_m1) begin
            sub <= '0;
            st  <= st + 2'd1;
         end else begin
            sub <= sub + DEN_W'(1);
         end
      end else if (rev) begin
         if (sub == '0) begin
            sub <= n_m1;
            st  <= st - 2'd1;
         end else begin
            sub <= sub - DEN_W'(1);
         end
      end
   end
endmodule

// File: rtl/qdp_edge_div.sv
module qdp_edge_div #(
   parameter int DEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic             a_cur,
   input  logic             a_prev,
   input  logic             b_cur,
   input  logic [DEN_W-1:0] n_m1,
   output logic             a_div,
   output logic             lead_b
);
   logic [DEN_W-1:0] cnt;
   logic             a_edge, a_rise;

   assign a_edge = en && (a_cur ^ a_prev);
   assign a_rise = en && a_cur && !a_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         a_div  <= 1'b0;
         lead_b <= 1'b0;
      end else if (clr) begin
         cnt    <= '0;
         a_div  <= 1'b0;
         lead_b <= 1'b0;
      end else begin
         if (a_edge) begin
            if (cnt == n_m1) begin
               cnt   <= '0;
               a_div <= ~a_div;
            end else begin
               cnt <= cnt + DEN_W'(1);
            end
         end
         if (a_rise) lead_b <= b_cur;
      end
   end
endmodule

// File: rtl/quad_pulse_divider.sv
module quad_pulse_divider
   import qdp_pkg::*;
#(
   parameter int DEN_W       = 8,
   parameter int SYNC_STAGES = 2,
   localparam int SW_W       = DEN_W + 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            enc_a_i,
   input  logic            enc_b_i,
   input  logic            enc_z_i,
   input  logic [SW_W-1:0] cfg_sw_n_i,
   output logic            a_out_o,
   output logic            b_out_o,
   output logic            z_out_o
);
   if (DEN_W < 1 || DEN_W > 16) begin : g_bad_den
      $error("quad_pulse_divider: DEN_W must be 1..16");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("quad_pulse_divider: SYNC_STAGES must be at least 2");
   end

   logic [SW_W-1:0]  sw;
   logic [DEN_W-1:0] den, n_m1;
   logic             run, lead_sel, ext_sel, rsv_unused;
   omode_e           mode;
   lvl_t             cur, prev;
   logic [1:0]       st;
   logic             a_div, lead_b;

   assign sw         = ~cfg_sw_n_i;
   assign rsv_unused = sw[0];
   assign ext_sel    = sw[1];
   assign lead_sel   = sw[2];
   assign run        = sw[3];
   assign den        = sw[SW_W-1:4];
   assign n_m1       = (den == '0) ? '0 : den - DEN_W'(1);

   always_comb begin
      if (ext_sel)       mode = OM_EXTDIR;
      else if (lead_sel) mode = OM_LEAD;
      else               mode = OM_QUAD;
   end

   qdp_front #(.STAGES(SYNC_STAGES)) u_front (
      .clk   (clk),
      .rst_n (rst_n),
      .a_i   (enc_a_i),
      .b_i   (enc_b_i),
      .z_i   (enc_z_i),
      .cur   (cur),
      .prev  (prev)
   );

   qdp_quad_cnt #(.DEN_W(DEN_W)) u_quad (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!run),
      .en    (mode == OM_QUAD),
      .cur   (cur),
      .prev  (prev),
      .n_m1  (n_m1),
      .st    (st)
   );

   qdp_edge_div #(.DEN_W(DEN_W)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (!run),
      .en     (mode != OM_QUAD),
      .a_cur  (cur.a),
      .a_prev (prev.a),
      .b_cur  (cur.b),
      .n_m1   (n_m1),
      .a_div  (a_div),
      .lead_b (lead_b)
   );

   always_comb begin
      unique case (mode)
         OM_QUAD: begin
            a_out_o = st[1] ^ st[0];
            b_out_o = st[1];
         end
         OM_LEAD: begin
            a_out_o = a_div;
            b_out_o = lead_b;
         end
         default: begin
            a_out_o = a_div;
            b_out_o = prev.b;
         end
      endcase
   end

   assign z_out_o = prev.z;
endmodule

// File: rtl/quad_pulse_divider_chk.sv
module quad_pulse_divider_chk #(
   parameter int SW_W = 12
) (
   input logic            clk,
   input logic            rst_n,
   input logic            enc_b_i,
   input logic            enc_z_i,
   input logic [SW_W-1:0] cfg_sw_n_i,
   input logic            a_out_o,
   input logic            b_out_o,
   input logic            z_out_o
);
   logic [2:0] cyc;
   logic       hold, ext, quad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cyc <= '0;
      else if (cyc != 3'd7)  cyc <= cyc + 3'd1;
   end

   assign hold = cfg_sw_n_i[3];
   assign ext  = !cfg_sw_n_i[1];
   assign quad = cfg_sw_n_i[1] && cfg_sw_n_i[2];

   p_index_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 3'd3) |-> (z_out_o == $past(enc_z_i, 3)));

   p_ext_dir_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 3'd3 && ext) |-> (b_out_o == $past(enc_b_i, 3)));

   p_hold_a_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> !a_out_o);

   p_hold_b_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !ext) |=> (!b_out_o || !cfg_sw_n_i[1]));

   p_one_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 3'd1 && quad && !hold && $stable(cfg_sw_n_i))
      |-> $onehot0({a_out_o, b_out_o} ^ $past({a_out_o, b_out_o})));
endmodule

bind quad_pulse_divider quad_pulse_divider_chk #(.SW_W(SW_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .enc_b_i    (enc_b_i),
   .enc_z_i    (enc_z_i),
   .cfg_sw_n_i (cfg_sw_n_i),
   .a_out_o    (a_out_o),
   .b_out_o    (b_out_o),
   .z_out_o    (z_out_o)
);

// File: tb/test_quad_pulse_divider.sv
module test_quad_pulse_divider;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        a_i = 1'b0, b_i = 1'b0, z_i = 1'b0;
   logic [11:0] sw = 12'hFFF;
   logic        a_o, b_o, z_o;

   always #5 clk = ~clk;

   quad_pulse_divider i_quad_pulse_divider (
      .clk        (clk),
      .rst_n      (rst_n),
      .enc_a_i    (a_i),
      .enc_b_i    (b_i),
      .enc_z_i    (z_i),
      .cfg_sw_n_i (sw),
      .a_out_o    (a_o),
      .b_out_o    (b_o),
      .z_out_o    (z_o)
   );

   typedef struct {
      logic  a;
      logic  b;
      string tag;
   } exp_t;

   exp_t  exp_q[$];
   int    checks = 0, fails = 0;
   int    idx = 0, pos = 0, nden = 1, aedges = 0;
   bit    dirv = 0, md_lead = 0, md_ext = 0, hold = 1, rsv_b = 0;
   int    cur_den = 0;
   string tag = "R8";

   task automatic check(input string t, input string what, input logic act, input logic expv);
      checks++;
      if (act !== expv) begin
         fails++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", t, what, act, expv, $time);
      end
   endtask

   // raw active-low word: position1 rsv, 2 ext, 3 lead, 4 run, 5..12 denominator (5 = LSB)
   function automatic logic [11:0] raw(input int den, input bit run, input bit lead,
                                       input bit ext, input bit rsv);
      logic [7:0] d8;
      d8 = den[7:0];
      return ~{d8, run, lead, ext, rsv};
   endfunction

   // monitor: pops expected items and compares against the outputs
   initial begin
      forever begin
         exp_t e;
         wait (exp_q.size() != 0);
         e = exp_q.pop_front();
         check(e.tag, "A_out", a_o, e.a);
         check(e.tag, "B_out", b_o, e.b);
      end
   end

   function automatic exp_t model();
      exp_t e;
      int   s;
      e.tag = tag;
      if (md_ext || md_lead) begin
         e.a = ((aedges / nden) % 2) == 1;
         e.b = md_ext ? b_i : dirv;
      end else begin
         s   = (pos / nden) % 4;
         e.a = (s == 1) || (s == 2);
         e.b = (s >= 2);
      end
      return e;
   endfunction

   task automatic step(input int d);
      logic old_a;
      idx   = (idx + d + 4) % 4;
      old_a = a_i;
      a_i   = (idx == 1) || (idx == 2);
      b_i   = (idx >= 2);
      if (!hold) begin
         if (md_ext || md_lead) begin
            if (a_i != old_a) aedges++;
            if (a_i && !old_a) dirv = b_i;
         end else begin
            pos = (pos + d + 4 * nden) % (4 * nden);
         end
      end
      repeat (4) @(negedge clk);
      exp_q.push_back(model());
      #1;
   endtask

   task automatic steps(input int n, input int d);
      for (int i = 0; i < n; i++) step(d);
   endtask

   task automatic configure(input int den, input bit lead, input bit ext, input bit rsv);
      sw = raw(den, 1'b0, lead, ext, rsv);
      repeat (3) @(negedge clk);
      sw = raw(den, 1'b1, lead, ext, rsv);
      repeat (2) @(negedge clk);
      cur_den = den; md_lead = lead; md_ext = ext; rsv_b = rsv;
      nden = (den == 0) ? 1 : den;
      pos = 0; aedges = 0; dirv = 0; hold = 0;
   endtask

   task automatic set_hold(input bit h);
      sw = raw(cur_den, !h, md_lead, md_ext, rsv_b);
      repeat (2) @(negedge clk);
      hold = h;
      if (h) begin
         pos = 0; aedges = 0; dirv = 0;
      end
   endtask

   task automatic z_probe(input logic v);
      z_i = v;
      repeat (2) @(negedge clk);
      check("R7", "Z_out before latency", z_o, !v);
      @(negedge clk);
      check("R7", "Z_out at latency", z_o, v);
   endtask

   initial begin
      fork
         begin
            repeat (150000) @(posedge clk);
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
         end
      join_none

      repeat (3) @(negedge clk);
      // R8: reset state is cleared
      check("R8", "A_out in reset", a_o, 1'b0);
      check("R8", "B_out in reset", b_o, 1'b0);
      check("R7", "Z_out in reset", z_o, 1'b0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1: all raw pins 1 -> every field 0 -> held clear
      tag = "R1"; hold = 1;
      steps(6, 1);

      tag = "R3"; configure(3, 0, 0, 0);
      steps(30, 1);
      steps(20, -1);

      // R10: exact latency with N=1
      tag = "R10"; configure(1, 0, 0, 0);
      while (idx != 0) step(1);
      a_i = 1'b1; idx = 1; pos = 1;
      repeat (2) @(negedge clk);
      check("R10", "A_out before latency", a_o, 1'b0);
      @(negedge clk);
      check("R10", "A_out at latency", a_o, 1'b1);
      check("R10", "B_out at latency", b_o, 1'b0);

      tag = "R4"; configure(0, 0, 0, 0);
      steps(9, 1);
      steps(5, -1);

      tag = "R2"; configure(6, 0, 0, 0);
      steps(30, 1);
      configure(85, 1, 0, 0);
      steps(345, 1);

      tag = "R5"; configure(2, 1, 0, 0);
      steps(12, 1);
      steps(12, -1);
      steps(4, 1);

      tag = "R6"; configure(4, 0, 1, 0);
      steps(10, 1);
      steps(7, -1);
      configure(4, 1, 1, 0);
      steps(9, 1);

      tag = "R8"; configure(3, 0, 0, 0);
      steps(7, 1);
      set_hold(1);
      exp_q.push_back(model());
      #1;
      steps(6, 1);
      set_hold(0);
      steps(8, 1);
      configure(2, 1, 0, 0);
      steps(6, -1);
      set_hold(1);
      steps(4, -1);
      set_hold(0);
      steps(5, -1);

      tag = "R9"; configure(3, 0, 0, 1);
      steps(20, 1);
      steps(5, -1);

      z_probe(1'b1);
      z_probe(1'b0);
      configure(5, 0, 1, 0);
      set_hold(1);
      z_probe(1'b1);
      z_probe(1'b0);

      repeat (4) @(negedge clk);
      wait (exp_q.size() == 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule